// File: doc/BRIEF.md
# Peripheral Security Selector

This block sits on the peripheral bus as a small register-mapped slave. It drives one output bit per protected peripheral, and that bit feeds the peripheral's secure/non-secure select input on the system bridge. A bit value of 1 marks the peripheral as non-secure and 0 marks it as secure. A few extra control outputs are also provided for other system-level enables, such as a debug-enable line.

The treatment of each peripheral bit is fixed when the block is built. A bit is either tied secure, tied non-secure, or left programmable. Secure software moves a programmable peripheral into the non-secure world and back by writing 1s to a set register or a clear register. A status register reports the whole vector. The controller treats itself as a secure peripheral. Every access that arrives with the non-secure protection attribute is refused with an error response, reads back zero and changes nothing.

Register offsets are byte addresses and are decoded as the word index `paddr[ADDR_W-1:2]`:

| Offset | Register | Behaviour |
|---|---|---|
| 0x0 | status | Read: the current peripheral vector |
| 0x4 | set | Write 1 to make a programmable bit non-secure |
| 0x8 | clear | Write 1 to make a programmable bit secure |
| 0xC | aux | Read/write the extra control outputs |

Top module: `perisec_ctrl`

## Requirements
- R1: `periph_ns_o` has bit value 1 for non-secure and 0 for secure. Bits in `FIX_SEC_MASK` are always 0. Bits in `FIX_NS_MASK` and not in `FIX_SEC_MASK` are always 1. This holds whatever is written, and the secure mask wins where the two masks overlap.
- R2: While reset is asserted, every programmable bit of `periph_ns_o` is 0 (secure) and `aux_ctrl_o` equals `AUX_RST`.
- R3: A secure write to offset 0x4 sets to 1 each programmable bit whose `pwdata` bit is 1. All other bits keep their value.
- R4: A secure write to offset 0x8 clears to 0 each programmable bit whose `pwdata` bit is 1. All other bits keep their value.
- R5: A secure read of offset 0x0 returns `periph_ns_o` in `prdata[NUM_PERIPH-1:0]`, with the upper bits 0. Reads of 0x4 and 0x8 return 0.
- R6: A secure write to offset 0xC loads `pwdata[NUM_AUX-1:0]` into `aux_ctrl_o`. A secure read of 0xC returns it in the low bits, with the upper bits 0.
- R7: An access with `pprot[1]`=1 (non-secure) drives `pslverr`=1 and `prdata`=0 in its access phase, and changes no output.
- R8: Outputs change only on the rising edge that ends a write access phase (`psel`, `penable` and `pwrite` all high). A setup phase alone or an idle cycle leaves them unchanged. `pready` is 1 in every access phase.
- R9: A secure access to an offset of 0x10 or above reads 0, has `pslverr`=0, and its writes change nothing.
- R10: Every secure access has `pslverr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pprot | input | 3 | Protection attribute; bit 1 set = non-secure |
| prdata | output | DATA_W | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error response for non-secure accesses |
| periph_ns_o | output | NUM_PERIPH | Per-peripheral security select, 1 = non-secure |
| aux_ctrl_o | output | NUM_AUX | Extra system control outputs |

## Verification
`prdata`, `pslverr` and `pready` are combinational and are due in the access-phase cycle itself. The bench compares them in the falling-edge half of that cycle. The registered outputs `periph_ns_o` and `aux_ctrl_o` change on the rising edge that ends a write access, so a reference model updated on that same edge is compared with them at every falling edge, where any early or late change shows up as a mismatch. Reset takes effect at once on assertion. On release it is held for two more clocks, and the bench issues no access in that window.

// File: rtl/perisec_pkg.sv
`timescale 1ns/1ps
package perisec_pkg;

  // Word index of each register (paddr[3:2] once the upper offset bits are zero)
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_SET    = 2'd1,
    REG_CLR    = 2'd2,
    REG_AUX    = 2'd3
  } reg_sel_e;

  // Decoded write strobes for the current completing transfer
  typedef struct packed {
    logic set;
    logic clr;
    logic aux;
  } wr_req_t;

endpackage

// File: rtl/perisec_rst_sync.sv
`timescale 1ns/1ps
// Asserts reset asynchronously and releases it after STAGES clock edges.
module perisec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/perisec_apb_dec.sv
`timescale 1ns/1ps
// Transfer decode and access checking: only secure transfers may touch state.
module perisec_apb_dec
  import perisec_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [2:0]        pprot,
  output wr_req_t           wr,
  output logic              rd_en,
  output reg_sel_e          rd_sel,
  output logic              err
);

  localparam int OFS_W = ADDR_W - 2;

  logic [OFS_W-1:0] ofs;
  logic             access;
  logic             secure;
  logic             hit;
  logic             wr_ok;
  reg_sel_e         sel;
  logic             unused_bits;

  assign ofs         = paddr[ADDR_W-1:2];
  assign access      = psel & penable;
  assign secure      = ~pprot[1];
  assign hit         = (ofs[OFS_W-1:2] == '0);
  assign sel         = reg_sel_e'(ofs[1:0]);
  assign unused_bits = ^{paddr[1:0], pprot[2], pprot[0]};

  always_comb begin
    wr_ok  = access & pwrite & secure & hit;
    wr.set = wr_ok & (sel == REG_SET);
    wr.clr = wr_ok & (sel == REG_CLR);
    wr.aux = wr_ok & (sel == REG_AUX);
    rd_en  = access & ~pwrite & secure & hit;
    rd_sel = sel;
    err    = access & ~secure;
  end

endmodule

// File: rtl/perisec_prog_bit.sv
`timescale 1ns/1ps
// One software-programmable security bit; clear has priority over set.
module perisec_prog_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_r;
  logic q_d;
  logic en;

  always_comb begin
    en  = set_i | clr_i;
    q_d = q_r;
    if (clr_i) begin
      q_d = 1'b0;
    end else if (set_i) begin
      q_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST_VAL;
    end else if (en) begin
      q_r <= q_d;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/perisec_aux_reg.sv
`timescale 1ns/1ps
// Extra control outputs, loaded whole by a secure write.
module perisec_aux_reg #(
  parameter int           WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = we ? wdata : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST_VAL;
    end else if (we) begin
      q_r <= q_d;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/perisec_ctrl.sv
`timescale 1ns/1ps
module perisec_ctrl
  import perisec_pkg::*;
#(
  parameter int                    NUM_PERIPH   = 8,
  parameter int                    NUM_AUX      = 2,
  parameter int                    ADDR_W       = 12,
  parameter int                    DATA_W       = 32,
  parameter int                    SYNC_STAGES  = 2,
  parameter logic [NUM_PERIPH-1:0] FIX_SEC_MASK = 8'h01,
  parameter logic [NUM_PERIPH-1:0] FIX_NS_MASK  = 8'h06,
  parameter logic [NUM_AUX-1:0]    AUX_RST      = '0
) (
  input  logic                  pclk,
  input  logic                  presetn,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  input  logic [2:0]            pprot,
  output logic [DATA_W-1:0]     prdata,
  output logic                  pready,
  output logic                  pslverr,
  output logic [NUM_PERIPH-1:0] periph_ns_o,
  output logic [NUM_AUX-1:0]    aux_ctrl_o
);

  // Secure mask wins where both masks claim a bit
  localparam logic [NUM_PERIPH-1:0] FIX_NS_EFF = FIX_NS_MASK & ~FIX_SEC_MASK;
  localparam logic [NUM_PERIPH-1:0] PROG_MASK  = ~(FIX_SEC_MASK | FIX_NS_MASK);

  logic                  rst_n_sync;
  wr_req_t               wr;
  logic                  rd_en;
  reg_sel_e              rd_sel;
  logic                  dec_err;
  logic [NUM_PERIPH-1:0] ns_q;
  logic [NUM_AUX-1:0]    aux_q;
  logic [DATA_W-1:0]     rd_data;
  logic                  unused_wdata;

  assign unused_wdata = ^pwdata;

  perisec_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_n_sync)
  );

  perisec_apb_dec #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pprot   (pprot),
    .wr      (wr),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .err     (dec_err)
  );

  // Build-time choice per bit: a register slice or a tied constant
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
    if (PROG_MASK[i]) begin : g_prog
      perisec_prog_bit #(
        .RST_VAL (1'b0)
      ) u_bit (
        .clk   (pclk),
        .rst_n (rst_n_sync),
        .set_i (wr.set & pwdata[i]),
        .clr_i (wr.clr & pwdata[i]),
        .q_o   (ns_q[i])
      );
    end else begin : g_fixed
      assign ns_q[i] = FIX_NS_EFF[i];
    end
  end

  perisec_aux_reg #(
    .WIDTH   (NUM_AUX),
    .RST_VAL (AUX_RST)
  ) u_aux (
    .clk   (pclk),
    .rst_n (rst_n_sync),
    .we    (wr.aux),
    .wdata (pwdata[NUM_AUX-1:0]),
    .q_o   (aux_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_sel)
        REG_STATUS: rd_data[NUM_PERIPH-1:0] = ns_q;
        REG_AUX:    rd_data[NUM_AUX-1:0]    = aux_q;
        default:    rd_data                 = '0;
      endcase
    end
  end

  assign prdata      = rd_data;
  assign pready      = 1'b1;
  assign pslverr     = dec_err;
  assign periph_ns_o = ns_q;
  assign aux_ctrl_o  = aux_q;

endmodule

// File: rtl/perisec_ctrl_chk.sv
`timescale 1ns/1ps
module perisec_ctrl_chk #(
  parameter int                    NUM_PERIPH   = 8,
  parameter int                    NUM_AUX      = 2,
  parameter int                    DATA_W       = 32,
  parameter logic [NUM_PERIPH-1:0] FIX_SEC_MASK = 8'h01,
  parameter logic [NUM_PERIPH-1:0] FIX_NS_MASK  = 8'h06
) (
  input logic                  pclk,
  input logic                  presetn,
  input logic                  psel,
  input logic                  penable,
  input logic                  pwrite,
  input logic [2:0]            pprot,
  input logic [DATA_W-1:0]     prdata,
  input logic                  pslverr,
  input logic [NUM_PERIPH-1:0] periph_ns_o,
  input logic [NUM_AUX-1:0]    aux_ctrl_o
);

  localparam logic [NUM_PERIPH-1:0] NS_EFF = FIX_NS_MASK & ~FIX_SEC_MASK;

  a_r1_fixed_sec_low: assert property (@(posedge pclk) disable iff (!presetn)
    (periph_ns_o & FIX_SEC_MASK) == '0);

  a_r1_fixed_ns_high: assert property (@(posedge pclk) disable iff (!presetn)
    (periph_ns_o & NS_EFF) == NS_EFF);

  a_r7_ns_error: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pprot[1]) |-> (pslverr && prdata == '0));

  a_r7_ns_no_update: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pprot[1]) |=> ($stable(periph_ns_o) && $stable(aux_ctrl_o)));

  a_r8_hold_without_write: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite) |=> ($stable(periph_ns_o) && $stable(aux_ctrl_o)));

  a_r10_secure_no_error: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pprot[1]) |-> !pslverr);

endmodule

bind perisec_ctrl perisec_ctrl_chk #(
  .NUM_PERIPH   (NUM_PERIPH),
  .NUM_AUX      (NUM_AUX),
  .DATA_W       (DATA_W),
  .FIX_SEC_MASK (FIX_SEC_MASK),
  .FIX_NS_MASK  (FIX_NS_MASK)
) i_chk (
  .pclk        (pclk),
  .presetn     (presetn),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .pprot       (pprot),
  .prdata      (prdata),
  .pslverr     (pslverr),
  .periph_ns_o (periph_ns_o),
  .aux_ctrl_o  (aux_ctrl_o)
);

// File: tb/test_perisec_ctrl.sv
`timescale 1ns/1ps
module test_perisec_ctrl;

  localparam int             NP     = 8;
  localparam int             NA     = 2;
  localparam int             AW     = 12;
  localparam int             DW     = 32;
  localparam logic [NP-1:0]  SEC_M  = 8'h01;
  localparam logic [NP-1:0]  NS_M   = 8'h06;
  localparam logic [NP-1:0]  PROG_M = 8'hF8;
  localparam logic [NA-1:0]  AUX_R  = 2'b10;

  logic          pclk = 1'b0;
  logic          presetn = 1'b0;
  logic          psel = 1'b0;
  logic          penable = 1'b0;
  logic          pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [2:0]    pprot = '0;
  logic [DW-1:0] prdata;
  logic          pready;
  logic          pslverr;
  logic [NP-1:0] periph_ns_o;
  logic [NA-1:0] aux_ctrl_o;

  int    n_chk = 0;
  int    n_err = 0;
  bit    chk_en = 1'b0;
  bit    done = 1'b0;
  string cur_tag = "R2";

  logic [NP-1:0] m_ns;
  logic [NA-1:0] m_aux;

  always #2 pclk = ~pclk;

  perisec_ctrl #(
    .NUM_PERIPH   (NP),
    .NUM_AUX      (NA),
    .ADDR_W       (AW),
    .DATA_W       (DW),
    .SYNC_STAGES  (2),
    .FIX_SEC_MASK (SEC_M),
    .FIX_NS_MASK  (NS_M),
    .AUX_RST      (AUX_R)
  ) i_perisec_ctrl (
    .pclk        (pclk),
    .presetn     (presetn),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .pprot       (pprot),
    .prdata      (prdata),
    .pready      (pready),
    .pslverr     (pslverr),
    .periph_ns_o (periph_ns_o),
    .aux_ctrl_o  (aux_ctrl_o)
  );

  // Reference model: state after each completed secure write
  always @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      m_ns  = NS_M;
      m_aux = AUX_R;
    end else if (psel && penable && pwrite && !pprot[1]) begin
      case (paddr)
        12'h004: m_ns  = m_ns | (pwdata[NP-1:0] & PROG_M);
        12'h008: m_ns  = m_ns & ~(pwdata[NP-1:0] & PROG_M);
        12'h00C: m_aux = pwdata[NA-1:0];
        default: ;
      endcase
    end
  end

  function automatic logic [DW-1:0] exp_rd();
    logic [DW-1:0] r = '0;
    if (!pprot[1] && !pwrite) begin
      if (paddr == 12'h000) r[NP-1:0] = m_ns;
      else if (paddr == 12'h00C) r[NA-1:0] = m_aux;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge pclk) begin
    if (chk_en) begin
      check(cur_tag, DW'(periph_ns_o), DW'(m_ns), "periph_ns_o");
      check(cur_tag, DW'(aux_ctrl_o), DW'(m_aux), "aux_ctrl_o");
      if (psel && penable) begin
        check(cur_tag, prdata, exp_rd(), "prdata");
        check(cur_tag, DW'(pslverr), DW'(pprot[1]), "pslverr");
        check(cur_tag, DW'(pready), DW'(1'b1), "pready");
      end
    end
  end

  task automatic apb(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ns);
    @(posedge pclk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d; pprot = {1'b0, ns, 1'b0};
    @(posedge pclk); #1;
    penable = 1'b1;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge pclk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_5EED;
    // R2: reset values
    repeat (3) @(posedge pclk);
    #1 chk_en = 1'b1;
    check("R2", DW'(periph_ns_o), DW'(NS_M), "reset periph_ns_o");
    check("R2", DW'(aux_ctrl_o), DW'(AUX_R), "reset aux_ctrl_o");
    presetn = 1'b1;
    repeat (4) @(posedge pclk);

    cur_tag = "R5";
    apb(1'b0, 12'h000, '0, 1'b0);
    apb(1'b0, 12'h004, '0, 1'b0);
    apb(1'b0, 12'h008, '0, 1'b0);

    cur_tag = "R1";
    apb(1'b1, 12'h004, 32'hFFFF_FFFF, 1'b0);
    apb(1'b1, 12'h008, 32'h0000_0006, 1'b0);
    apb(1'b0, 12'h000, '0, 1'b0);
    #1 check("R1", DW'(periph_ns_o), 32'hFE, "fixed bits after set all/clear");

    cur_tag = "R4";
    apb(1'b1, 12'h008, 32'h0000_0028, 1'b0);
    apb(1'b0, 12'h000, '0, 1'b0);
    #1 check("R4", DW'(periph_ns_o), 32'hD6, "after clear 0x28");

    cur_tag = "R3";
    apb(1'b1, 12'h004, 32'h0000_0008, 1'b0);
    apb(1'b0, 12'h000, '0, 1'b0);
    #1 check("R3", DW'(periph_ns_o), 32'hDE, "after set 0x08");

    cur_tag = "R6";
    apb(1'b1, 12'h00C, 32'hFFFF_FFF1, 1'b0);
    apb(1'b0, 12'h00C, '0, 1'b0);
    #1 check("R6", DW'(aux_ctrl_o), 32'h1, "aux after write");

    cur_tag = "R7";
    apb(1'b1, 12'h008, 32'hFFFF_FFFF, 1'b1);
    apb(1'b1, 12'h00C, 32'h2, 1'b1);
    apb(1'b0, 12'h000, '0, 1'b1);
    #1 check("R7", DW'(periph_ns_o), 32'hDE, "vector after non-secure writes");
    check("R7", DW'(aux_ctrl_o), 32'h1, "aux after non-secure write");

    cur_tag = "R9";
    apb(1'b1, 12'h010, 32'hFFFF_FFFF, 1'b0);
    apb(1'b1, 12'h3FC, 32'h0, 1'b0);
    apb(1'b0, 12'h010, '0, 1'b0);
    apb(1'b0, 12'h014, '0, 1'b0);
    #1 check("R9", DW'(periph_ns_o), 32'hDE, "vector after unmapped writes");

    cur_tag = "R8";
    @(posedge pclk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'hFF; pprot = 3'b000;
    repeat (2) @(posedge pclk); #1;
    psel = 1'b0;
    @(posedge pclk); #1;
    check("R8", DW'(periph_ns_o), 32'hDE, "setup-only phase made no change");

    cur_tag = "R10";
    apb(1'b0, 12'h000, '0, 1'b0);
    apb(1'b1, 12'h008, 32'h10, 1'b0);
    apb(1'b0, 12'h00C, '0, 1'b0);

    cur_tag = "R8";
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apb(lfsr[3], {7'b0, lfsr[6:4] % 3'd6, 2'b00}, {lfsr[15:8], lfsr[31:8]}, lfsr[7] & lfsr[2]);
    end

    cur_tag = "R2";
    apb(1'b1, 12'h004, 32'hFF, 1'b0);
    @(posedge pclk); #1 presetn = 1'b0;
    @(negedge pclk);
    check("R2", DW'(periph_ns_o), DW'(NS_M), "vector in second reset");
    check("R2", DW'(aux_ctrl_o), DW'(AUX_R), "aux in second reset");
    @(posedge pclk); #1 presetn = 1'b1;
    repeat (4) @(posedge pclk);
    cur_tag = "R5";
    apb(1'b0, 12'h000, '0, 1'b0);
    repeat (2) @(posedge pclk);
    finish_run();
  end

endmodule